// File: doc/BRIEF.md
# Single-Channel Peripheral-Mode DMA Engine

This block is one DMA channel that services a fixed peripheral location. Software (or a neighbouring controller) loads a 24-bit memory pointer, an 8-bit peripheral offset, a transfer count and a control word, then sets the enable bit. Each request accepted after that moves exactly one byte or one 16-bit word between memory and the peripheral. A transfer is a single-beat read on the bus followed by a single-beat write, and each beat waits for the bus to signal ready.

Which request line fired decides the direction. The serial-receive line moves data from the peripheral into memory, and every other line moves data from memory out to the peripheral. The peripheral address always sits in the top page of the 24-bit space and never moves. The memory pointer steps after every unit. When the count is used up, the channel turns itself off, raises a sticky done flag and can pulse an interrupt.

Top module: `dma_io_chan`

## Requirements
- R1: While reset is held and after it is released, the channel is idle: no bus strobe, busy, done, irq and enable all low, and count and memory pointer zero.
- R2: An accepted request produces a read beat (bus_rd) on the source address that holds until bus_rdy is high at a clock edge. The next cycle starts a write beat (bus_wr) on the destination address carrying the data just read, also held until bus_rdy. The two strobes are never high together.
- R3: If the winning request is line RX_SRC (line 0 by default), the source is the peripheral address and the destination is the memory pointer. Any other line gives the reverse. When several lines are high, the lowest-numbered line wins.
- R4: The peripheral address on the bus is the 8-bit offset with all upper 16 bits set to one. The offset is never stepped.
- R5: After each completed write beat the memory pointer moves by 2 in word mode (ctrl bit 1 = 1) or by 1 in byte mode. Ctrl bit 2 = 1 steps down and 0 steps up. The pointer wraps modulo 2^24.
- R6: The count drops by one after each completed write beat, and the run ends on the beat that takes it from 1 to 0. A loaded count of 0 gives 2^CW transfers.
- R7: On the final beat the enable bit (ctrl bit 0) clears and done sets and stays set. irq is high for exactly one cycle, and only when ctrl bit 3 is set.
- R8: Requests are ignored while a transfer is in progress or while the channel is disabled. No strobe appears and neither pointer nor count moves.
- R9: Register writes (cfg_sel 0 pointer, 1 offset, 2 count, 3 control) take effect only while the channel is not busy. Any accepted control write clears done.
- R10: bus_word follows the word-mode control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 pointer, 1 offset, 2 count, 3 control |
| cfg_wdata | input | AW | Register write data |
| req | input | NSRC | Transfer request lines, one per activation source |
| bus_rdata | input | DW | Read data from the bus |
| bus_rdy | input | 1 | Bus beat completes at this edge |
| bus_rd | output | 1 | Read beat strobe |
| bus_wr | output | 1 | Write beat strobe |
| bus_word | output | 1 | Beat size: 1 word, 0 byte |
| bus_addr | output | AW | Beat address, zero when idle |
| bus_wdata | output | DW | Write data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Sticky end-of-run flag |
| irq | output | 1 | One-cycle end-of-run interrupt |
| st_en | output | 1 | Current enable bit |
| st_maddr | output | AW | Current memory pointer |
| st_count | output | CW | Remaining transfer count |

## Verification
The bench builds the channel with CW = 4 and keeps the other defaults: four request lines, with line 0 as serial receive. The narrow count means a loaded zero runs its full 16 transfers, so the wrap-to-maximum count case can be reached in a short run. Runs are made with zero, one and two wait cycles per beat, with both directions and both sizes, with simultaneous request lines, and with a downward word run that crosses address zero.

// File: rtl/dma_io_pkg.sv
package dma_io_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_t;

  localparam logic [1:0] SEL_MADDR = 2'd0;
  localparam logic [1:0] SEL_IOOFF = 2'd1;
  localparam logic [1:0] SEL_CNT   = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_WORD = 1;
  localparam int CB_DEC  = 2;
  localparam int CB_IE   = 3;

endpackage

// File: rtl/dma_io_reqsel.sv
module dma_io_reqsel #(
  parameter int NSRC   = 4,
  parameter int RX_SRC = 0
) (
  input  logic [NSRC-1:0] req,
  output logic            any_req,
  output logic            rx_win
);

  logic [NSRC:0]   seen;
  logic [NSRC-1:0] win;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NSRC; g++) begin : g_pri
    assign seen[g+1] = seen[g] | req[g];
    assign win[g]    = req[g] & ~seen[g];
  end

  assign any_req = seen[NSRC];
  assign rx_win  = win[RX_SRC];

endmodule

// File: rtl/dma_io_regs.sv
module dma_io_regs
  import dma_io_pkg::*;
#(
  parameter int AW = 24,
  parameter int IW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          xfer_done,
  output logic [AW-1:0] maddr,
  output logic [IW-1:0] io_off,
  output logic [CW-1:0] count,
  output logic          en,
  output logic          word,
  output logic          dec,
  output logic          irq_en,
  output logic          done,
  output logic          irq
);

  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] maddr_n;
  logic [IW-1:0] io_off_n;
  logic [CW-1:0] count_n;
  logic          en_n, word_n, dec_n, irq_en_n, done_n, irq_n;
  logic [AW-1:0] step;
  logic          last;
  logic          cfg_ok;

  assign step   = word ? STEP_W : STEP_B;
  assign last   = (count == CNT_ONE);
  assign cfg_ok = cfg_we & ~busy;

  always_comb begin
    maddr_n  = maddr;
    io_off_n = io_off;
    count_n  = count;
    en_n     = en;
    word_n   = word;
    dec_n    = dec;
    irq_en_n = irq_en;
    done_n   = done;
    irq_n    = 1'b0;
    if (xfer_done) begin
      maddr_n = dec ? (maddr - step) : (maddr + step);
      count_n = count - CNT_ONE;
      if (last) begin
        en_n   = 1'b0;
        done_n = 1'b1;
        irq_n  = irq_en;
      end
    end else if (cfg_ok) begin
      unique case (cfg_sel)
        SEL_MADDR: maddr_n  = cfg_wdata;
        SEL_IOOFF: io_off_n = cfg_wdata[IW-1:0];
        SEL_CNT:   count_n  = cfg_wdata[CW-1:0];
        SEL_CTRL: begin
          en_n     = cfg_wdata[CB_EN];
          word_n   = cfg_wdata[CB_WORD];
          dec_n    = cfg_wdata[CB_DEC];
          irq_en_n = cfg_wdata[CB_IE];
          done_n   = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr  <= '0;
      io_off <= '0;
      count  <= '0;
      en     <= 1'b0;
      word   <= 1'b0;
      dec    <= 1'b0;
      irq_en <= 1'b0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      maddr  <= maddr_n;
      io_off <= io_off_n;
      count  <= count_n;
      en     <= en_n;
      word   <= word_n;
      dec    <= dec_n;
      irq_en <= irq_en_n;
      done   <= done_n;
      irq    <= irq_n;
    end
  end

endmodule

// File: rtl/dma_io_fsm.sv
module dma_io_fsm
  import dma_io_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          any_req,
  input  logic          rx_win,
  input  logic          bus_rdy,
  input  logic [DW-1:0] bus_rdata,
  output logic          rd_act,
  output logic          wr_act,
  output logic          rx_dir,
  output logic          xfer_done,
  output logic [DW-1:0] data_q
);

  xfer_st_t st, st_n;
  logic     rx_n;
  logic     data_ld;
  logic     start;

  assign start     = (st == ST_IDLE) & en & any_req;
  assign data_ld   = (st == ST_RD) & bus_rdy;
  assign xfer_done = (st == ST_WR) & bus_rdy;
  assign rd_act    = (st == ST_RD);
  assign wr_act    = (st == ST_WR);

  always_comb begin
    st_n = st;
    rx_n = rx_dir;
    unique case (st)
      ST_IDLE: if (start) begin
        st_n = ST_RD;
        rx_n = rx_win;
      end
      ST_RD:   if (bus_rdy) st_n = ST_WR;
      ST_WR:   if (bus_rdy) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rx_dir <= 1'b0;
    end else begin
      st     <= st_n;
      rx_dir <= rx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_ld) begin
      data_q <= bus_rdata;
    end
  end

endmodule

// File: rtl/dma_io_chan.sv
module dma_io_chan
  import dma_io_pkg::*;
#(
  parameter int AW     = 24,
  parameter int IW     = 8,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int NSRC   = 4,
  parameter int RX_SRC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [NSRC-1:0] req,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_rdy,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            bus_word,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            busy,
  output logic            done,
  output logic            irq,
  output logic            st_en,
  output logic [AW-1:0]   st_maddr,
  output logic [CW-1:0]   st_count
);

  localparam int PW = AW - IW;

  logic          rst_m, rst_q;
  logic          any_req, rx_win, rx_dir, xfer_done;
  logic          word, dec, irq_en;
  logic [IW-1:0] io_off;
  logic [AW-1:0] io_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  dma_io_reqsel #(.NSRC(NSRC), .RX_SRC(RX_SRC)) u_reqsel (
    .req     (req),
    .any_req (any_req),
    .rx_win  (rx_win)
  );

  dma_io_regs #(.AW(AW), .IW(IW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .xfer_done (xfer_done),
    .maddr     (st_maddr),
    .io_off    (io_off),
    .count     (st_count),
    .en        (st_en),
    .word      (word),
    .dec       (dec),
    .irq_en    (irq_en),
    .done      (done),
    .irq       (irq)
  );

  dma_io_fsm #(.DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_q),
    .en        (st_en),
    .any_req   (any_req),
    .rx_win    (rx_win),
    .bus_rdy   (bus_rdy),
    .bus_rdata (bus_rdata),
    .rd_act    (bus_rd),
    .wr_act    (bus_wr),
    .rx_dir    (rx_dir),
    .xfer_done (xfer_done),
    .data_q    (bus_wdata)
  );

  assign io_addr  = {{PW{1'b1}}, io_off};
  assign busy     = bus_rd | bus_wr;
  assign bus_word = word;

  always_comb begin
    bus_addr = '0;
    if (bus_rd)      bus_addr = rx_dir ? io_addr : st_maddr;
    else if (bus_wr) bus_addr = rx_dir ? st_maddr : io_addr;
  end

endmodule

// File: rtl/dma_io_chan_chk.sv
module dma_io_chan_chk
  import dma_io_pkg::*;
#(
  parameter int AW = 24,
  parameter int IW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_rdy,
  input logic [AW-1:0] bus_addr,
  input logic [AW-1:0] st_maddr,
  input logic [CW-1:0] st_count,
  input logic          st_en,
  input logic          busy,
  input logic          done,
  input logic          irq,
  input logic          word,
  input logic          dec,
  input logic [IW-1:0] io_off,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel
);

  logic [AW-1:0] stp;
  logic [AW-1:0] page_addr;
  assign stp       = word ? AW'(2) : AW'(1);
  assign page_addr = {{(AW-IW){1'b1}}, io_off};

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_rdy |=> bus_rd && $stable(bus_addr));

  p_rd_to_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_rdy |=> bus_wr);

  p_io_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_addr == st_maddr) || (bus_addr == page_addr));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_rdy |=> st_maddr == ($past(dec) ? $past(st_maddr) - $past(stp)
                                                  : $past(st_maddr) + $past(stp)));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_rdy |=> st_count == $past(st_count) - CW'(1));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_end_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !st_en && !busy);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_rd && !bus_wr);

  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we && cfg_sel == SEL_IOOFF |=> $stable(io_off));

endmodule

bind dma_io_chan dma_io_chan_chk #(.AW(AW), .IW(IW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_rdy  (bus_rdy),
  .bus_addr (bus_addr),
  .st_maddr (st_maddr),
  .st_count (st_count),
  .st_en    (st_en),
  .busy     (busy),
  .done     (done),
  .irq      (irq),
  .word     (word),
  .dec      (dec),
  .io_off   (io_off),
  .cfg_we   (cfg_we),
  .cfg_sel  (cfg_sel)
);

// File: tb/dma_io_chan_bench.sv
module dma_io_chan_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24, IW = 8, DW = 16, CW = 4, NSRC = 4, RX_SRC = 0;
  localparam int WDOG = 20000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = '0;
  logic [AW-1:0]   cfg_wdata = '0;
  logic [NSRC-1:0] req = '0;
  logic [DW-1:0]   bus_rdata;
  logic            bus_rdy = 1'b0;
  logic            bus_rd, bus_wr, bus_word, busy, done, irq, st_en;
  logic [AW-1:0]   bus_addr, st_maddr;
  logic [DW-1:0]   bus_wdata;
  logic [CW-1:0]   st_count;

  int checks = 0, fails = 0, cycles = 0, wait_n = 0, wcnt = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_io_chan #(.AW(AW), .IW(IW), .DW(DW), .CW(CW), .NSRC(NSRC), .RX_SRC(RX_SRC))
  u_dma_io_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req(req), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .done(done), .irq(irq), .st_en(st_en), .st_maddr(st_maddr), .st_count(st_count)
  );

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {a[23:16], a[23:16]};
  endfunction

  assign bus_rdata = mem_fn(bus_addr);

  // behavioural reference: 0 idle, 1 read beat, 2 write beat
  int            m_st;
  logic [AW-1:0] m_maddr;
  logic [IW-1:0] m_io;
  int            m_cnt;
  bit            m_en, m_word, m_dec, m_ie, m_done, m_irq, m_rx;
  logic [DW-1:0] m_data;

  function automatic logic [AW-1:0] m_ioa();
    return {16'hFFFF, m_io};
  endfunction

  always @(posedge clk) begin
    int ps, first, stp;
    bit xd;
    if (!rst_n) begin
      m_st = 0; m_maddr = '0; m_io = '0; m_cnt = 0; m_en = 0; m_word = 0;
      m_dec = 0; m_ie = 0; m_done = 0; m_irq = 0; m_rx = 0; m_data = '0;
    end else begin
      ps = m_st;
      xd = (ps == 2) && bus_rdy;
      m_irq = 0;
      if (ps == 0) begin
        if (m_en && req != '0) begin
          first = -1;
          for (int i = NSRC - 1; i >= 0; i--) if (req[i]) first = i;
          m_rx = (first == RX_SRC);
          m_st = 1;
        end
      end else if (ps == 1) begin
        if (bus_rdy) begin
          m_data = mem_fn(m_rx ? m_ioa() : m_maddr);
          m_st = 2;
        end
      end else if (bus_rdy) begin
        m_st = 0;
      end
      if (xd) begin
        stp = m_word ? 2 : 1;
        m_maddr = m_dec ? m_maddr - AW'(stp) : m_maddr + AW'(stp);
        if (m_cnt == 1) begin
          m_en = 0; m_done = 1; m_irq = m_ie;
        end
        m_cnt = (m_cnt + (1 << CW) - 1) % (1 << CW);
      end else if (cfg_we && ps == 0) begin
        case (cfg_sel)
          2'd0: m_maddr = cfg_wdata;
          2'd1: m_io = cfg_wdata[IW-1:0];
          2'd2: m_cnt = int'(cfg_wdata[CW-1:0]);
          default: begin
            m_en = cfg_wdata[0]; m_word = cfg_wdata[1];
            m_dec = cfg_wdata[2]; m_ie = cfg_wdata[3]; m_done = 0;
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // compare every cycle against the reference
  always @(negedge clk) begin
    logic [AW-1:0] ea;
    cycles++;
    if (cycles > WDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WDOG);
      report();
    end
    if (cmp_on) begin
      ea = '0;
      if (m_st == 1) ea = m_rx ? m_ioa() : m_maddr;
      if (m_st == 2) ea = m_rx ? m_maddr : m_ioa();
      chk("R2 bus_rd", 32'(bus_rd), 32'(m_st == 1));
      chk("R2 bus_wr", 32'(bus_wr), 32'(m_st == 2));
      chk("R3/R4 bus_addr", 32'(bus_addr), 32'(ea));
      if (m_st == 2) chk("R2 bus_wdata", 32'(bus_wdata), 32'(m_data));
      chk("R8 busy", 32'(busy), 32'(m_st != 0));
      chk("R5 st_maddr", 32'(st_maddr), 32'(m_maddr));
      chk("R6 st_count", 32'(st_count), 32'(m_cnt));
      chk("R7 st_en", 32'(st_en), 32'(m_en));
      chk("R7 done", 32'(done), 32'(m_done));
      chk("R7 irq", 32'(irq), 32'(m_irq));
      chk("R10 bus_word", 32'(bus_word), 32'(m_word));
    end
  end

  // bus responder with programmable wait cycles
  always @(negedge clk) begin
    #2;
    if (m_st != 0) begin
      if (wcnt >= wait_n) begin bus_rdy = 1'b1; wcnt = 0; end
      else begin bus_rdy = 1'b0; wcnt++; end
    end else begin
      bus_rdy = 1'b0; wcnt = 0;
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (st_en || busy) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    cmp_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 bus_rd", 32'(bus_rd), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 st_en", 32'(st_en), 0);
    chk("R1 st_count", 32'(st_count), 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: requests while disabled do nothing
    #1 req = 4'b0010;
    repeat (3) @(negedge clk);
    chk("R8 disabled busy", 32'(busy), 0);
    #1 req = '0;

    // byte, up, transmit direction, no wait states
    wait_n = 0;
    cfg(2'd0, 24'h001000);
    cfg(2'd1, 24'h000040);
    cfg(2'd2, 24'd3);
    cfg(2'd3, 24'b1001);
    #1 req = 4'b0010;
    wait_end();
    chk("R5 byte up", 32'(st_maddr), 32'h001003);
    chk("R6 count end", 32'(st_count), 0);
    chk("R7 done", 32'(done), 1);
    chk("R7 en cleared", 32'(st_en), 0);
    repeat (4) @(negedge clk);
    chk("R8 ignored after end", 32'(st_maddr), 32'h001003);
    #1 req = '0;

    // R9: control write clears done
    cfg(2'd3, 24'b0000);
    chk("R9 done cleared", 32'(done), 0);

    // word, down across zero, receive wins over line 2, two wait states
    wait_n = 2;
    cfg(2'd0, 24'h000002);
    cfg(2'd1, 24'h00007E);
    cfg(2'd2, 24'd2);
    cfg(2'd3, 24'b1111);
    #1 req = 4'b0101;
    wait_end();
    #1 req = '0;
    chk("R5 word down wrap", 32'(st_maddr), 32'hFFFFFE);
    chk("R3 rx run done", 32'(done), 1);

    // zero count = 2^CW transfers, word up, no irq, writes during busy ignored
    wait_n = 1;
    cfg(2'd3, 24'b0000);
    cfg(2'd0, 24'h00ABC0);
    cfg(2'd2, 24'd0);
    cfg(2'd3, 24'b0011);
    #1 req = 4'b1000;
    @(negedge clk);
    while (!busy) @(negedge clk);
    #1 cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 24'h000011;
    @(negedge clk); #1 cfg_we = 1'b0;
    while (!busy) @(negedge clk);
    #1 cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 24'h000000;
    @(negedge clk); #1 cfg_we = 1'b0;
    wait_end();
    #1 req = '0;
    chk("R6 zero count runs 16", 32'(st_maddr), 32'h00ABE0);
    chk("R9 busy write ignored", 32'(st_maddr[23:16]), 32'h00);
    chk("R7 no irq, done set", 32'(done), 1);

    repeat (3) @(negedge clk);
    report();
  end

endmodule